// File: doc/BRIEF.md
# Reconfigurable Pin Function Crossbar

This block sits between a chip's general-purpose pads and its on-chip peripherals. It serves 24 pins, grouped as three ports of eight. Each pin has a 5-bit routing code. That code picks two things at once: the peripheral output that drives the pin, and the peripheral input that the pin feeds. Software-visible routing codes are written and read through a simple synchronous write port and a combinational read port.

The code also sets who controls the pad. Serial-interface codes hand the output enable to the peripheral's own direction request. The two-wire bus clock and data codes turn the pin into an open-drain driver while that bus mode is active. One code isolates the pin for analog use by switching off both its driver and its input buffer. When a pin's function-select bit is clear, its code is ignored and the pin follows its plain GPIO data and direction bits.

On the input side, every peripheral input function is the OR of all pins routed to it. Timer clear and fault inputs are further gated by their timer's input enable.

Top module: `pin_xbar`

## Requirements
- R1: Each routing register holds 5 bits. A write stores `wr_data[4:0]` at the next rising clock edge and discards the upper bits, so writing 0xFF reads back 31. `rd_data` shows the addressed register combinationally. Writes to an address of 24 or above are ignored, and reading such an address returns 0.
- R2: After reset, pin i (i = 0..23, with pin 0 being bit 0 of the first port) holds code i+1.
- R3: With the function select set, codes 0 and 30 drive the pin low, take the output enable from `gpio_dir`, keep the input buffer on, and feed no input function.
- R4: With the function select set, code 31 forces `pad_oe`, `pad_ie` and `pad_out` to 0 and feeds no input function.
- R5: With the function select set, codes 7 to 29 drive `pad_out` from `fn_out[code]`, take the output enable from `gpio_dir`, and feed `pad_in` into `fn_in[code]`.
- R6: With the function select set, codes 1 to 6 (outside open-drain mode) take `pad_out` from `fn_out[code]` and `pad_oe` from `fn_dir[code]`, whatever `gpio_dir` is. The pin also feeds `fn_in[code]`.
- R7: While `i2c_mode` is high, codes 3 (clock) and 5 (data) make the pin open-drain. `pad_out` is 0 and `pad_oe` is the inverse of `fn_out[code]`.
- R8: The input functions for codes 13 to 15 read 0 unless `tmr0_ien` is high. The input functions for codes 16 to 18 read 0 unless `tmr1_ien` is high.
- R9: With the function select clear, `pad_out` equals `gpio_out`, `pad_oe` equals `gpio_dir`, `pad_ie` is 1, and the pin feeds no input function.
- R10: Each `fn_in` bit is the OR of `pad_in` over all pins routed to that code with their select set. A code with no such pin reads 0, and `fn_in` bits 0, 30 and 31 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for a routing register |
| wr_addr | input | 5 | Pin index to write |
| wr_data | input | 8 | Write data; only bits 4:0 are kept |
| rd_addr | input | 5 | Pin index to read |
| rd_data | output | 5 | Routing code of the addressed pin |
| gpio_sel | input | 24 | Per-pin function select (1 = routed, 0 = GPIO) |
| gpio_out | input | 24 | Per-pin GPIO data |
| gpio_dir | input | 24 | Per-pin GPIO direction (1 = output) |
| pad_in | input | 24 | Pad input levels |
| pad_out | output | 24 | Pad output levels |
| pad_oe | output | 24 | Pad output enables |
| pad_ie | output | 24 | Pad input-buffer enables |
| fn_out | input | 32 | Peripheral output function, indexed by code |
| fn_dir | input | 32 | Peripheral direction request, indexed by code |
| i2c_mode | input | 1 | Serial unit in two-wire bus mode |
| tmr0_ien | input | 1 | First timer's input enable (codes 13-15) |
| tmr1_ien | input | 1 | Second timer's input enable (codes 16-18) |
| fn_in | output | 32 | Peripheral input function, indexed by code |

## Verification
A corrupted routing register shows up in the same cycle in three places: on `rd_data`, on the pad drive of that pin, and on the `fn_in` bit it feeds. A wrong reset code is visible on the first read after reset. A misclassified code instead shows as the wrong owner of `pad_oe`, for example when `gpio_dir` and `fn_dir` are set to opposite values. A leak through the input-enable gates or through reserved codes shows as a `fn_in` bit that is 1 when no enabled pin is routed to it. The bench sets up those opposing values on purpose, so each fault is seen without delay.

// File: rtl/pxb_pkg.sv
package pxb_pkg;
  localparam int CODE_W    = 5;
  localparam int NUM_CODES = 1 << CODE_W;

  localparam logic [CODE_W-1:0] C_IDLE     = 5'd0;
  localparam logic [CODE_W-1:0] C_SER_LO   = 5'd1;
  localparam logic [CODE_W-1:0] C_SER_HI   = 5'd6;
  localparam logic [CODE_W-1:0] C_TWI_CLK  = 5'd3;
  localparam logic [CODE_W-1:0] C_TWI_DAT  = 5'd5;
  localparam logic [CODE_W-1:0] C_T0_G_LO  = 5'd13;
  localparam logic [CODE_W-1:0] C_T0_G_HI  = 5'd15;
  localparam logic [CODE_W-1:0] C_T1_G_LO  = 5'd16;
  localparam logic [CODE_W-1:0] C_T1_G_HI  = 5'd18;
  localparam logic [CODE_W-1:0] C_RESV     = 5'd30;
  localparam logic [CODE_W-1:0] C_ANALOG   = 5'd31;

  typedef enum logic [1:0] {
    K_IDLE,
    K_SERIAL,
    K_PLAIN,
    K_ANALOG
  } code_kind_e;

  function automatic code_kind_e classify(input logic [CODE_W-1:0] c);
    if (c == C_IDLE || c == C_RESV)        return K_IDLE;
    else if (c == C_ANALOG)                return K_ANALOG;
    else if (c >= C_SER_LO && c <= C_SER_HI) return K_SERIAL;
    else                                   return K_PLAIN;
  endfunction

  function automatic logic [NUM_CODES-1:0] range_mask(input logic [CODE_W-1:0] lo,
                                                      input logic [CODE_W-1:0] hi);
    logic [NUM_CODES-1:0] m;
    m = '0;
    for (int k = 0; k < NUM_CODES; k++) begin
      if (k >= int'(lo) && k <= int'(hi)) m[k] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/pxb_rst_sync.sv
module pxb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/pxb_regs.sv
module pxb_regs
  import pxb_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [DATA_W-1:0]                 wr_data,
  input  logic [ADDR_W-1:0]                 rd_addr,
  output logic [CODE_W-1:0]                 rd_data,
  output logic [NUM_PINS-1:0][CODE_W-1:0]   map_o
);
  logic [NUM_PINS-1:0][CODE_W-1:0] map_q;
  logic [NUM_PINS-1:0][CODE_W-1:0] map_d;
  logic                            wr_hit;

  assign wr_hit = wr_en && (int'(wr_addr) < NUM_PINS);

  // next state: only the low CODE_W bits of the write data are kept
  always_comb begin
    map_d = map_q;
    if (wr_hit) map_d[wr_addr] = wr_data[CODE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PINS; i++) map_q[i] <= CODE_W'(i + 1);
    end else if (wr_hit) begin
      map_q <= map_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_addr) < NUM_PINS) rd_data = map_q[rd_addr];
  end

  assign map_o = map_q;

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && (int'($past(wr_addr)) < NUM_PINS))
      |-> (map_q[$past(wr_addr)] == $past(wr_data[CODE_W-1:0]))); // R1
  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_addr) >= NUM_PINS) |-> (rd_data == '0)); // R1
endmodule

// File: rtl/pxb_pin_ctl.sv
module pxb_pin_ctl
  import pxb_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CODE_W-1:0]     code,
  input  logic                  sel,
  input  logic                  gpio_out,
  input  logic                  gpio_dir,
  input  logic                  pad_in,
  input  logic [NUM_CODES-1:0]  fn_out,
  input  logic [NUM_CODES-1:0]  fn_dir,
  input  logic                  i2c_mode,
  output logic                  pad_out,
  output logic                  pad_oe,
  output logic                  pad_ie,
  output logic [NUM_CODES-1:0]  feed
);
  code_kind_e kind;
  logic       open_drain;
  logic       fo;
  logic       fd;

  always_comb begin
    kind       = classify(code);
    open_drain = i2c_mode && (code == C_TWI_CLK || code == C_TWI_DAT);
    fo         = fn_out[code];
    fd         = fn_dir[code];
    feed       = '0;
    pad_out    = gpio_out;
    pad_oe     = gpio_dir;
    pad_ie     = 1'b1;
    if (sel) begin
      unique case (kind)
        K_IDLE: begin
          pad_out = 1'b0;
          pad_oe  = gpio_dir;
        end
        K_ANALOG: begin
          pad_out = 1'b0;
          pad_oe  = 1'b0;
          pad_ie  = 1'b0;
        end
        K_SERIAL: begin
          if (open_drain) begin
            pad_out = 1'b0;
            pad_oe  = ~fo;
          end else begin
            pad_out = fo;
            pad_oe  = fd;
          end
          feed[code] = pad_in;
        end
        default: begin
          pad_out    = fo;
          pad_oe     = gpio_dir;
          feed[code] = pad_in;
        end
      endcase
    end
  end

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && (code == C_IDLE || code == C_RESV)) |-> (!pad_out && feed == '0)); // R3
  AST_ANALOG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && code == C_ANALOG) |-> (!pad_oe && !pad_ie && feed == '0)); // R4
  AST_SERIAL_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !i2c_mode && code >= C_SER_LO && code <= C_SER_HI) |-> (pad_oe == fn_dir[code])); // R6
  AST_OPEN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && i2c_mode && (code == C_TWI_CLK || code == C_TWI_DAT)) |-> !pad_out); // R7
  AST_GPIO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> (pad_out == gpio_out && pad_oe == gpio_dir && pad_ie && feed == '0)); // R9
endmodule

// File: rtl/pxb_in_merge.sv
module pxb_in_merge
  import pxb_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NUM_PINS-1:0][NUM_CODES-1:0]  feed,
  input  logic                                tmr0_ien,
  input  logic                                tmr1_ien,
  output logic [NUM_CODES-1:0]                fn_in
);
  localparam logic [NUM_CODES-1:0] T0_MASK = range_mask(C_T0_G_LO, C_T0_G_HI);
  localparam logic [NUM_CODES-1:0] T1_MASK = range_mask(C_T1_G_LO, C_T1_G_HI);

  logic [NUM_CODES-1:0] any_pin;
  logic [NUM_CODES-1:0] gate;

  always_comb begin
    any_pin = '0;
    for (int p = 0; p < NUM_PINS; p++) any_pin = any_pin | feed[p];
  end

  always_comb begin
    gate = '1;
    if (!tmr0_ien) gate = gate & ~T0_MASK;
    if (!tmr1_ien) gate = gate & ~T1_MASK;
  end

  assign fn_in = any_pin & gate;

  AST_T0_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr0_ien |-> ((fn_in & T0_MASK) == '0)); // R8
  AST_T1_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr1_ien |-> ((fn_in & T1_MASK) == '0)); // R8
  AST_DEAD_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    (!fn_in[C_IDLE] && !fn_in[C_RESV] && !fn_in[C_ANALOG])); // R10
endmodule

// File: rtl/pin_xbar.sv
module pin_xbar
  import pxb_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int PORT_W    = 8,
  parameter int DATA_W    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [4:0]                   wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [4:0]                   rd_addr,
  output logic [CODE_W-1:0]            rd_data,
  input  logic [NUM_PORTS*PORT_W-1:0]  gpio_sel,
  input  logic [NUM_PORTS*PORT_W-1:0]  gpio_out,
  input  logic [NUM_PORTS*PORT_W-1:0]  gpio_dir,
  input  logic [NUM_PORTS*PORT_W-1:0]  pad_in,
  output logic [NUM_PORTS*PORT_W-1:0]  pad_out,
  output logic [NUM_PORTS*PORT_W-1:0]  pad_oe,
  output logic [NUM_PORTS*PORT_W-1:0]  pad_ie,
  input  logic [NUM_CODES-1:0]         fn_out,
  input  logic [NUM_CODES-1:0]         fn_dir,
  input  logic                         i2c_mode,
  input  logic                         tmr0_ien,
  input  logic                         tmr1_ien,
  output logic [NUM_CODES-1:0]         fn_in
);
  localparam int NUM_PINS = NUM_PORTS * PORT_W;
  localparam int ADDR_W   = 5;

  logic                                rst_sync_n;
  logic [NUM_PINS-1:0][CODE_W-1:0]     map;
  logic [NUM_PINS-1:0][NUM_CODES-1:0]  feed;

  pxb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pxb_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .map_o   (map)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    pxb_pin_ctl u_pin (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .code     (map[g]),
      .sel      (gpio_sel[g]),
      .gpio_out (gpio_out[g]),
      .gpio_dir (gpio_dir[g]),
      .pad_in   (pad_in[g]),
      .fn_out   (fn_out),
      .fn_dir   (fn_dir),
      .i2c_mode (i2c_mode),
      .pad_out  (pad_out[g]),
      .pad_oe   (pad_oe[g]),
      .pad_ie   (pad_ie[g]),
      .feed     (feed[g])
    );
  end

  pxb_in_merge #(.NUM_PINS(NUM_PINS)) u_merge (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .feed     (feed),
    .tmr0_ien (tmr0_ien),
    .tmr1_ien (tmr1_ien),
    .fn_in    (fn_in)
  );
endmodule

// File: tb/pin_xbar_test.sv
`timescale 1ns/1ps
module pin_xbar_test;
  logic        clk, rst_n, wr_en, i2c_mode, tmr0_ien, tmr1_ien;
  logic [4:0]  wr_addr, rd_addr, rd_data;
  logic [7:0]  wr_data;
  logic [23:0] gpio_sel, gpio_out, gpio_dir, pad_in, pad_out, pad_oe, pad_ie;
  logic [31:0] fn_out, fn_dir, fn_in;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  pin_xbar uut (.*);

  initial clk = 0;
  always #4 clk = ~clk;

  // vector: [19:16] req, [15:11] code, sel, dir, gout, fo, fd, i2c, pin | exp out, oe, ie, fn_in[code]
  localparam int NV = 14;
  localparam logic [19:0] VEC [NV] = '{
    {4'd3, 5'd0,  7'b1110001, 4'b0110},  // R3 code 0 low, dir owns oe
    {4'd3, 5'd30, 7'b1011101, 4'b0010},  // R3 reserved code
    {4'd4, 5'd31, 7'b1111101, 4'b0000},  // R4 analog isolation
    {4'd5, 5'd7,  7'b1101001, 4'b1111},  // R5 plain timer code
    {4'd5, 5'd7,  7'b1000000, 4'b0010},  // R5 plain, dir low
    {4'd5, 5'd24, 7'b1101001, 4'b1111},  // R5 top default code
    {4'd6, 5'd2,  7'b1001100, 4'b1110},  // R6 peripheral sets oe against dir
    {4'd6, 5'd2,  7'b1110001, 4'b0011},  // R6 peripheral clears oe against dir
    {4'd7, 5'd3,  7'b1000011, 4'b0111},  // R7 open-drain clock pulls low
    {4'd7, 5'd5,  7'b1001110, 4'b0010},  // R7 open-drain data released
    {4'd6, 5'd3,  7'b1001101, 4'b1111},  // R6 same code, bus mode off
    {4'd9, 5'd7,  7'b0110001, 4'b1110},  // R9 gpio passthrough
    {4'd9, 5'd31, 7'b0010001, 4'b1010},  // R9 analog code ignored
    {4'd5, 5'd13, 7'b1101001, 4'b1111}   // R5 gated code with enable
  };

  task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = 5'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    gpio_sel = 0; gpio_out = 0; gpio_dir = 0; pad_in = 0;
    fn_out = 0; fn_dir = 0; i2c_mode = 0; tmr0_ien = 1; tmr1_ien = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R2 reset codes
    for (int i = 0; i < 24; i++) begin
      rd_addr = 5'(i); #1;
      check(2, "reset code", 32'(rd_data), 32'(i + 1));
    end

    // R10 with defaults: every pin routed and high
    gpio_sel = '1; pad_in = '1; #1;
    check(10, "unmapped code 25", 32'(fn_in[25]), 0);
    check(10, "mapped code 24", 32'(fn_in[24]), 1);
    check(10, "code 0 input", 32'(fn_in[0]), 0);
    gpio_sel = 0; pad_in = 0;

    // R1 register width, range
    wr(0, 8'hFF); rd_addr = 0; #1;
    check(1, "0xFF readback", 32'(rd_data), 31);
    wr(0, 8'hE7); #1;
    check(1, "upper bits dropped", 32'(rd_data), 7);
    wr(24, 8'h03); rd_addr = 24; #1;
    check(1, "out of range read", 32'(rd_data), 0);
    rd_addr = 23; #1;
    check(1, "neighbour untouched", 32'(rd_data), 24);

    // vector table on pin 5
    for (int v = 0; v < NV; v++) begin
      logic [19:0] t;
      t = VEC[v];
      wr(5, {3'b000, t[15:11]});
      gpio_sel = 24'(t[10]) << 5;
      gpio_dir = {24{t[9]}};
      gpio_out = {24{t[8]}};
      fn_out   = {32{t[7]}};
      fn_dir   = {32{t[6]}};
      i2c_mode = t[5];
      pad_in   = {24{t[4]}};
      #1;
      check(int'(t[19:16]), $sformatf("vec %0d out", v), 32'(pad_out[5]), 32'(t[3]));
      check(int'(t[19:16]), $sformatf("vec %0d oe", v),  32'(pad_oe[5]),  32'(t[2]));
      check(int'(t[19:16]), $sformatf("vec %0d ie", v),  32'(pad_ie[5]),  32'(t[1]));
      check(int'(t[19:16]), $sformatf("vec %0d fn_in", v), 32'(fn_in[t[15:11]]), 32'(t[0]));
    end
    gpio_sel = 0; gpio_dir = 0; gpio_out = 0; fn_out = 0; fn_dir = 0; i2c_mode = 0; pad_in = 0;

    // R10 OR of several pins onto one code
    wr(8, 8'd0); wr(2, 8'd9); wr(9, 8'd9);
    gpio_sel = (24'd1 << 2) | (24'd1 << 9);
    pad_in = 24'd1 << 2; #1;
    check(10, "OR first pin", 32'(fn_in[9]), 1);
    pad_in = 24'd1 << 9; #1;
    check(10, "OR second pin", 32'(fn_in[9]), 1);
    pad_in = 0; #1;
    check(10, "OR none high", 32'(fn_in[9]), 0);

    // R8 input enable gating
    wr(2, 8'd14); pad_in = '1; tmr0_ien = 0; #1;
    check(8, "code 14 gated", 32'(fn_in[14]), 0);
    tmr0_ien = 1; #1;
    check(8, "code 14 open", 32'(fn_in[14]), 1);
    wr(2, 8'd17); tmr1_ien = 0; #1;
    check(8, "code 17 gated", 32'(fn_in[17]), 0);
    tmr1_ien = 1; #1;
    check(8, "code 17 open", 32'(fn_in[17]), 1);

    finish_run();
  end
endmodule